// File: doc/BRIEF.md
# DRAM Page-Mode Burst Read Sequencer

This block fetches a short burst of code bytes from an asynchronous DRAM over an 8-bit data path and returns them to a requester as 16-bit words. A request carries a byte address, an even byte count from 2 to 16 and a timing mode. The sequencer opens the row with a single RAS strobe, then steps through consecutive column addresses with CAS while holding the output enable active. It captures one byte at a fixed cadence and pairs each even byte (low half) with the next odd byte (high half).

Two page timings share one state machine. The standard page timing (mode 0) gives each byte a three-clock slot and captures the byte while CAS is still low. The extended-data-out timing (mode 1) gives each byte a two-clock slot and captures the byte one clock after CAS has returned high, relying on the memory holding its data until the enable rises or CAS falls again. After the burst the row strobe is held high for a parameterised number of precharge clocks before the next request can be taken.

Cycle numbers below count controller clocks: cycle 1 is the clock in which `ack` is high, step is 3 in mode 0 and 2 in mode 1, n is the byte count, and L = 6 + step*(n-1) is the cycle of the last capture.

Top module: `dram_burst_seq`

## Requirements
- R1: While reset is applied and afterwards until a request, `ras_n`, `cas_n` and `oe_n` are high and `ack`, `busy`, `done` and `word_valid` are low.
- R2: A `req` seen while idle raises `ack` for exactly one cycle (cycle 1) and `busy` from cycle 1; a `req` held during a burst or its precharge produces no further `ack` until `busy` has fallen, and the next `ack` comes in cycle L+PRECHARGE+2.
- R3: The row field (byte address bits above the column field) is on `dram_addr` when `ras_n` falls in cycle 2, and `ras_n` falls exactly once per burst and stays low through cycle L.
- R4: Byte k (k = 0..n-1) uses column address start column + k, driven when `cas_n` falls in cycle 5+step*k; `cas_n` stays low two cycles in mode 0 and one cycle in mode 1, rising in cycle 4+step*(k+1).
- R5: In mode 0 byte k is captured at the end of cycle 6+3k, so word j appears in cycle 7+3*(2j+1).
- R6: In mode 1 byte k is captured at the end of cycle 6+2k, after CAS has risen, so word j appears in cycle 7+2*(2j+1).
- R7: `oe_n` goes low in cycle 4 and stays low through the last capture; it rises in cycle L+1.
- R8: `word_data` = {byte 2j+1, byte 2j} with `word_valid` high for one cycle per word, n/2 words per burst.
- R9: `done` is high for exactly one cycle, cycle L+1, together with the final word.
- R10: `ras_n` rises in cycle L+1 and stays high for PRECHARGE cycles; `busy` first reads low in cycle L+PRECHARGE+1.
- R11: Bit 0 of `start_addr` is ignored: the first column is always even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Burst request, taken when idle |
| start_addr | input | ADDR_W | Byte address of the first byte |
| byte_count | input | CNT_W | Bytes to fetch, even, 2..MAX_BYTES |
| mode | input | 1 | 0 = standard page timing, 1 = extended-data-out timing |
| ack | output | 1 | One-cycle acceptance pulse |
| busy | output | 1 | High from acceptance until precharge ends |
| done | output | 1 | One-cycle end-of-burst pulse |
| word_data | output | 16 | Assembled word, odd byte in the upper half |
| word_valid | output | 1 | One-cycle strobe for word_data |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_dq | input | 8 | Data returned by the memory |

## Verification
The assertions assume the byte count is even and between 2 and MAX_BYTES, and that the burst stays inside one column page, so the column counter never wraps. They also assume the memory model returns data on the cadence of the selected mode and that the clock is free running from reset. The stimulus only requests even counts of 2, 4 and 16 with start columns well below the page end, and the bench's memory model returns garbage outside the data-valid window of the requested mode, so a capture in the wrong cycle shows up as a wrong byte or a wrong word cycle.

// File: rtl/dram_burst_pkg.sv
package dram_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_BURST,
        ST_DRAIN,
        ST_PRECH
    } seq_state_e;

    typedef enum logic {
        MODE_FPM = 1'b0,
        MODE_EDO = 1'b1
    } page_mode_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic oe_n;
        logic row_sel;
    } strobe_t;

    localparam logic [1:0] ROW_LAST_PHASE = 2'd2;

    function automatic logic [1:0] slot_last_phase(page_mode_e m);
        return (m == MODE_EDO) ? 2'd1 : 2'd2;
    endfunction

    function automatic int unsigned max_int(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_burst_fsm.sv
module dram_burst_fsm
    import dram_burst_pkg::*;
#(
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned PRECHARGE = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             mode,
    output logic             ack,
    output logic             busy,
    output logic             done,
    output logic             load,
    output logic             samp_en,
    output logic [IDX_W-1:0] byte_idx,
    output strobe_t          strobes
);

    localparam int unsigned PC_W = $clog2(PRECHARGE + 1);
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRECHARGE - 1);

    seq_state_e       state_q;
    page_mode_e       mode_q;
    logic [1:0]       phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] samp_idx_q;
    logic [PC_W-1:0]  pc_q;
    logic             ack_q;
    logic             samp_q;
    logic             done_q;

    logic [CNT_W-1:0] even_cnt;
    logic [CNT_W-1:0] last_cnt;
    logic             slot_end;
    logic             accept;

    assign even_cnt = {byte_count[CNT_W-1:1], 1'b0};
    assign last_cnt = even_cnt - CNT_W'(1);
    assign slot_end = (phase_q == slot_last_phase(mode_q));
    assign accept   = (state_q == ST_IDLE) && req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            mode_q     <= MODE_FPM;
            phase_q    <= '0;
            idx_q      <= '0;
            last_q     <= '0;
            samp_idx_q <= '0;
            pc_q       <= '0;
            ack_q      <= 1'b0;
            samp_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            ack_q  <= 1'b0;
            samp_q <= (state_q == ST_BURST) && (phase_q == 2'd1);
            done_q <= samp_q && (samp_idx_q == last_q);
            if (samp_q) begin
                samp_idx_q <= samp_idx_q + IDX_W'(1);
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q     <= page_mode_e'(mode);
                        last_q     <= last_cnt[IDX_W-1:0];
                        ack_q      <= 1'b1;
                        phase_q    <= '0;
                        idx_q      <= '0;
                        samp_idx_q <= '0;
                        state_q    <= ST_ROW;
                    end
                end
                ST_ROW: begin
                    if (phase_q == ROW_LAST_PHASE) begin
                        phase_q <= '0;
                        state_q <= ST_BURST;
                    end else begin
                        phase_q <= phase_q + 2'd1;
                    end
                end
                ST_BURST: begin
                    if (slot_end) begin
                        phase_q <= '0;
                        if (idx_q == last_q) begin
                            pc_q    <= '0;
                            state_q <= (mode_q == MODE_EDO) ? ST_DRAIN : ST_PRECH;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end else begin
                        phase_q <= phase_q + 2'd1;
                    end
                end
                ST_DRAIN: begin
                    pc_q    <= '0;
                    state_q <= ST_PRECH;
                end
                ST_PRECH: begin
                    if (pc_q == PC_LAST) begin
                        state_q <= ST_IDLE;
                    end else begin
                        pc_q <= pc_q + PC_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        strobes = '{ras_n: 1'b1, cas_n: 1'b1, oe_n: 1'b1, row_sel: 1'b0};
        unique case (state_q)
            ST_ROW: begin
                strobes.row_sel = 1'b1;
                strobes.ras_n   = (phase_q == 2'd0);
            end
            ST_BURST: begin
                strobes.ras_n = 1'b0;
                strobes.oe_n  = 1'b0;
                strobes.cas_n = (phase_q == 2'd0);
            end
            ST_DRAIN: begin
                strobes.ras_n = 1'b0;
                strobes.oe_n  = 1'b0;
            end
            default: ;
        endcase
    end

    assign ack      = ack_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign load     = accept;
    assign samp_en  = samp_q;
    assign byte_idx = idx_q;

    // R2: the acceptance pulse never lasts two cycles
    assert_ack_single_R2: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);

    // R3: the row is still closed in the acceptance cycle
    assert_row_closed_at_ack_R3: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> strobes.ras_n);

    // R3: a column strobe only ever occurs inside an open row
    assert_cas_inside_row_R3: assert property (@(posedge clk) disable iff (rst)
        !strobes.cas_n |-> !strobes.ras_n);

    // R7: every capture happens while the output enable is still active
    assert_oe_at_capture_R7: assert property (@(posedge clk) disable iff (rst)
        samp_q |-> (!strobes.oe_n && !strobes.ras_n));

    // R9: the end pulse follows a capture
    assert_done_after_capture_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(samp_q));

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned COL_W  = 8,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned MUX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic              row_sel,
    output logic [MUX_W-1:0]  dram_addr
);

    localparam int unsigned ROW_W = ADDR_W - COL_W;

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_base_q;
    logic [COL_W-1:0] col_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q      <= '0;
            col_base_q <= '0;
        end else if (load) begin
            row_q      <= start_addr[ADDR_W-1:COL_W];
            col_base_q <= {start_addr[COL_W-1:1], 1'b0};
        end
    end

    assign col_now   = col_base_q + COL_W'(byte_idx);
    assign dram_addr = row_sel ? MUX_W'(row_q) : MUX_W'(col_now);

    // R11: the column base is always even
    assert_even_base_R11: assert property (@(posedge clk) disable iff (rst)
        !col_base_q[0]);

endmodule

// File: rtl/dram_byte_packer.sv
module dram_byte_packer (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        samp_en,
    input  logic [7:0]  dq,
    output logic [15:0] word_data,
    output logic        word_valid
);

    logic [7:0]  low_q;
    logic        have_low_q;
    logic [15:0] word_q;
    logic        valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q      <= '0;
            have_low_q <= 1'b0;
            word_q     <= '0;
            valid_q    <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (clear) begin
                have_low_q <= 1'b0;
            end else if (samp_en) begin
                if (have_low_q) begin
                    word_q     <= {dq, low_q};
                    valid_q    <= 1'b1;
                    have_low_q <= 1'b0;
                end else begin
                    low_q      <= dq;
                    have_low_q <= 1'b1;
                end
            end
        end
    end

    assign word_data  = word_q;
    assign word_valid = valid_q;

    // R8: words are separated by at least one idle cycle
    assert_word_gap_R8: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
    import dram_burst_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned COL_W     = 8,
    parameter int unsigned MAX_BYTES = 16,
    parameter int unsigned PRECHARGE = 3,
    localparam int unsigned CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int unsigned MUX_W    = max_int(ADDR_W - COL_W, COL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              mode,
    output logic              ack,
    output logic              busy,
    output logic              done,
    output logic [15:0]       word_data,
    output logic              word_valid,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              oe_n,
    input  logic [7:0]        dram_dq
);

    localparam int unsigned IDX_W = $clog2(MAX_BYTES);

    strobe_t          strobes;
    logic             load;
    logic             samp_en;
    logic [IDX_W-1:0] byte_idx;

    dram_burst_fsm #(
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W),
        .PRECHARGE(PRECHARGE)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .byte_count(byte_count),
        .mode      (mode),
        .ack       (ack),
        .busy      (busy),
        .done      (done),
        .load      (load),
        .samp_en   (samp_en),
        .byte_idx  (byte_idx),
        .strobes   (strobes)
    );

    dram_addr_mux #(
        .ADDR_W(ADDR_W),
        .COL_W (COL_W),
        .IDX_W (IDX_W),
        .MUX_W (MUX_W)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .start_addr(start_addr),
        .byte_idx  (byte_idx),
        .row_sel   (strobes.row_sel),
        .dram_addr (dram_addr)
    );

    dram_byte_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .clear     (load),
        .samp_en   (samp_en),
        .dq        (dram_dq),
        .word_data (word_data),
        .word_valid(word_valid)
    );

    assign ras_n = strobes.ras_n;
    assign cas_n = strobes.cas_n;
    assign oe_n  = strobes.oe_n;

    // R9: the end pulse coincides with the final word
    assert_done_with_word_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> word_valid);

    // R2: no acceptance while a burst is in progress
    assert_no_ack_when_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack) |=> !ack || $past(!busy));

endmodule

// File: tb/dram_burst_seq_test.sv
`timescale 1ns/1ps
module dram_burst_seq_test;

    localparam int TRP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [15:0] start_addr = '0;
    logic [4:0]  byte_count = '0;
    logic        mode = 1'b0;
    logic        ack, busy, done, word_valid, ras_n, cas_n, oe_n;
    logic [15:0] word_data;
    logic [7:0]  dram_addr;
    logic [7:0]  dq_r = 8'hEE;

    always #2.5 clk = ~clk;

    dram_burst_seq #(.ADDR_W(16), .COL_W(8), .MAX_BYTES(16), .PRECHARGE(TRP)) uut (
        .clk(clk), .rst(rst), .req(req), .start_addr(start_addr),
        .byte_count(byte_count), .mode(mode), .ack(ack), .busy(busy),
        .done(done), .word_data(word_data), .word_valid(word_valid),
        .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
        .dram_dq(dq_r)
    );

    int checks = 0;
    int failures = 0;

    // monitor state
    int cyc = 0;
    int lim = 0;
    logic tb_mode = 1'b0;
    int ras_falls, ras_fall_cyc, ras_rise_cyc, oe_fall_cyc, oe_rise_cyc;
    int nf, nr, nw, done_cnt, done_cyc, busy_fall_cyc, ack_cnt, ack2_cyc, busy_c1;
    logic [7:0]  ras_fall_addr;
    int          cf_cyc [16];
    logic [7:0]  cf_col [16];
    int          cr_cyc [16];
    int          w_cyc [8];
    logic [15:0] w_dat [8];
    logic p_ras = 1'b1, p_cas = 1'b1, p_oe = 1'b1, p_busy = 1'b0;
    logic [7:0] r_row = '0, r_col = '0;

    function automatic logic [7:0] mem_byte(logic [7:0] r, logic [7:0] c);
        return c * 8'd7 + r * 8'd3 + 8'h11;
    endfunction

    always @(negedge clk) begin
        // memory model
        if (p_ras && !ras_n) r_row = dram_addr;
        if (p_cas && !cas_n) r_col = dram_addr;
        if (tb_mode) begin
            if (oe_n) dq_r = 8'hEE;
            else if (p_cas && !cas_n) dq_r = mem_byte(r_row, r_col);
        end else begin
            dq_r = (!cas_n && !oe_n) ? mem_byte(r_row, r_col) : 8'hEE;
        end
        // cycle-tagged monitor
        if (ack && cyc == 0) cyc = 1;
        else if (cyc != 0) cyc++;
        if (cyc != 0 && ack && cyc > 1 && ack2_cyc == 0) ack2_cyc = cyc;
        if (cyc != 0 && cyc <= lim) begin
            if (cyc == 1) busy_c1 = busy;
            if (ack) ack_cnt++;
            if (p_ras && !ras_n) begin ras_falls++; ras_fall_cyc = cyc; ras_fall_addr = dram_addr; end
            if (!p_ras && ras_n) ras_rise_cyc = cyc;
            if (p_cas && !cas_n && nf < 16) begin cf_cyc[nf] = cyc; cf_col[nf] = dram_addr; nf++; end
            if (!p_cas && cas_n && nr < 16) begin cr_cyc[nr] = cyc; nr++; end
            if (p_oe && !oe_n) oe_fall_cyc = cyc;
            if (!p_oe && oe_n) oe_rise_cyc = cyc;
            if (word_valid && nw < 8) begin w_cyc[nw] = cyc; w_dat[nw] = word_data; nw++; end
            if (done) begin done_cnt++; done_cyc = cyc; end
            if (p_busy && !busy && busy_fall_cyc == 0) busy_fall_cyc = cyc;
        end
        p_ras = ras_n; p_cas = cas_n; p_oe = oe_n; p_busy = busy;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic test_reset();
        @(posedge clk); #1;
        chk(ras_n && cas_n && oe_n, "R1 strobes in reset", {ras_n, cas_n, oe_n}, 7);
        chk(!ack && !busy && !done && !word_valid, "R1 flags in reset",
            {ack, busy, done, word_valid}, 0);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(ras_n && cas_n && oe_n, "R1 strobes idle", {ras_n, cas_n, oe_n}, 7);
        chk(!ack && !busy && !done && !word_valid, "R1 flags idle",
            {ack, busy, done, word_valid}, 0);
    endtask

    task automatic run_burst(input logic [15:0] sa, input int n, input logic md, input bit hold);
        int step, last, row, col0;
        string st;
        step = md ? 2 : 3;
        last = 6 + step * (n - 1);
        row  = sa[15:8];
        col0 = sa[7:0] & 8'hFE;
        st   = md ? "R6" : "R5";
        @(posedge clk); #1;
        tb_mode = md; lim = last + TRP + 1; cyc = 0;
        ras_falls = 0; ras_fall_cyc = 0; ras_rise_cyc = 0; oe_fall_cyc = 0; oe_rise_cyc = 0;
        nf = 0; nr = 0; nw = 0; done_cnt = 0; done_cyc = 0; busy_fall_cyc = 0;
        ack_cnt = 0; ack2_cyc = 0; busy_c1 = 0;
        req = 1'b1; start_addr = sa; byte_count = 5'(n); mode = md;
        while (cyc == 0) begin @(posedge clk); #1; end
        if (!hold) req = 1'b0;
        while (cyc < lim + 3) begin @(posedge clk); #1; end
        req = 1'b0;

        chk(ack_cnt == 1, "R2 single ack", ack_cnt, 1);
        chk(busy_c1 == 1, "R2 busy in cycle 1", busy_c1, 1);
        chk(ras_falls == 1, "R3 one row strobe", ras_falls, 1);
        chk(ras_fall_cyc == 2, "R3 row strobe cycle", ras_fall_cyc, 2);
        chk(ras_fall_addr == 8'(row), "R3 row address", ras_fall_addr, row);
        chk(nf == n && nr == n, "R4 column strobe count", nf, n);
        for (int k = 0; k < n && k < 16; k++) begin
            chk(cf_cyc[k] == 5 + step * k, "R4 CAS fall cycle", cf_cyc[k], 5 + step * k);
            chk(cr_cyc[k] == 4 + step * (k + 1), "R4 CAS rise cycle", cr_cyc[k], 4 + step * (k + 1));
            chk(cf_col[k] == 8'(col0 + k), (sa[0] ? "R11 even column" : "R4 column address"),
                cf_col[k], 8'(col0 + k));
        end
        chk(oe_fall_cyc == 4, "R7 OE fall cycle", oe_fall_cyc, 4);
        chk(oe_rise_cyc == last + 1, "R7 OE rise cycle", oe_rise_cyc, last + 1);
        chk(nw == n / 2, "R8 word count", nw, n / 2);
        for (int j = 0; j < n / 2 && j < 8; j++) begin
            logic [15:0] ew;
            ew = {mem_byte(8'(row), 8'(col0 + 2 * j + 1)), mem_byte(8'(row), 8'(col0 + 2 * j))};
            chk(w_cyc[j] == 7 + step * (2 * j + 1), st, w_cyc[j], 7 + step * (2 * j + 1));
            chk(w_dat[j] == ew, "R8 word value", w_dat[j], ew);
        end
        chk(done_cnt == 1 && done_cyc == last + 1, "R9 done cycle", done_cyc, last + 1);
        chk(ras_rise_cyc == last + 1, "R10 RAS precharge start", ras_rise_cyc, last + 1);
        chk(busy_fall_cyc == last + TRP + 1, "R10 busy release", busy_fall_cyc, last + TRP + 1);
        if (hold) begin
            chk(ack2_cyc == last + TRP + 2, "R2 held request accepted after precharge",
                ack2_cyc, last + TRP + 2);
            while (busy) begin @(posedge clk); #1; end
        end
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        test_reset();
        run_burst(16'h3A20, 4, 1'b0, 1'b0);   // R5 standard timing
        run_burst(16'h51C4, 4, 1'b1, 1'b0);   // R6 extended-data-out timing
        run_burst(16'h7F00, 16, 1'b0, 1'b0);  // longest burst, standard
        run_burst(16'h0210, 2, 1'b1, 1'b0);   // shortest burst, extended
        run_burst(16'hA435, 16, 1'b1, 1'b0);  // R11 odd start address
        run_burst(16'hC2E6, 2, 1'b0, 1'b1);   // R2 request held through precharge
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule